// File: doc/BRIEF.md
# Run-Length Write Scan Array

This block is a random-access scan store for test mode. It holds a grid of scan cells arranged as rows and columns, and a tester addresses the cells directly, as it would a small RAM. A write cycle does not have to touch a single cell. It can drive one data bit into a contiguous run of cells in one row. The run starts at a column address and covers that column plus the number of further columns given in a run-length field. A run that would pass the last column is cut off at the row's edge, so it never wraps into another row.

A read cycle selects one row and folds that row's cell states into a multiple-input signature register (MISR). The signature is then compared off-chip against a known good value. The width of the run-length field is a parameter, and it sets the most cells a single cycle can write. The column decoder can be built as a set of per-column comparators or as a pair of shifted masks. Both forms give the same enables.

Top module: `rscan_range_array`

## Requirements
- R1: After reset every cell reads 0 on `cell_q` and `signature` is 0.
- R2: A write with `run_len` = 0 changes only the cell at (`row_addr`, `col_addr`). Bit `row*COLS+col` of `cell_q` is that cell.
- R3: A write stores `scan_din` into every column from `col_addr` up to and including `col_addr + run_len` of the addressed row. All those cells take the same value one clock after the write.
- R4: With row 3, start column 2 and run length 4, columns 2, 3, 4, 5 and 6 of row 3 are written and no other cell changes.
- R5: Column enables beyond column COLS-1 are clipped. A run never alters cells in any other row, and never alters columns of its own row below the start.
- R6: A write happens only when `test_en` = 1 and `wr_mode` = 1. With `test_en` = 0, or during a read, all cells keep their values.
- R7: Cells of the addressed row that lie outside the enabled range keep their values during a write.
- R8: A read (`test_en` = 1, `wr_mode` = 0) updates the signature to {sig[COLS-2:0],0} XOR (sig[COLS-1] ? POLY : 0) XOR row, where row is the addressed row's cells with column c at bit c. The default POLY is 16'h002D.
- R9: The signature holds its value in every cycle that is not a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Enables a scan access this cycle |
| wr_mode | input | 1 | 1 = write run, 0 = read row into signature |
| row_addr | input | $clog2(ROWS) | Row address |
| col_addr | input | $clog2(COLS) | First column of the run |
| run_len | input | RUN_W | Extra columns beyond the first |
| scan_din | input | 1 | Data bit written to every enabled cell |
| cell_q | output | ROWS*COLS | Cell states, bit row*COLS+col |
| signature | output | COLS | MISR contents |

## Verification
A fault in the range decoder shows up on `cell_q` one clock after the faulty write. The symptom is a cell missing at the end of a run, a stray cell before the start, or a bit set in the following row where clipping failed. A wrong row select corrupts a different row's bits in that same cycle. The signature compounds any read-path error on every later read, so a single wrong row image stays visible in `signature` from the next cycle onward. The bench therefore compares the full cell image and the signature after every cycle, not only at the end.

// File: rtl/rscan_pkg.sv
package rscan_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2
   } rscan_op_e;

   function automatic rscan_op_e rscan_decode_op(input logic te, input logic wm);
      if (!te)     return OP_IDLE;
      else if (wm) return OP_WRITE;
      else         return OP_READ;
   endfunction
endpackage

// File: rtl/rscan_row_dec.sv
module rscan_row_dec #(
   parameter int unsigned ROWS = 8,
   localparam int unsigned RAW = $clog2(ROWS)
) (
   input  logic [RAW-1:0]  row_addr,
   input  logic            enable,
   output logic [ROWS-1:0] row_sel
);
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam logic [RAW-1:0] RIDX = RAW'(r);
      assign row_sel[r] = enable && (row_addr == RIDX);
   end
endmodule

// File: rtl/rscan_col_range_dec.sv
module rscan_col_range_dec #(
   parameter int unsigned COLS  = 16,
   parameter int unsigned RUN_W = 3,
   parameter int unsigned STYLE = 0,
   localparam int unsigned CAW  = $clog2(COLS),
   localparam int unsigned SUMW = ((CAW > RUN_W) ? CAW : RUN_W) + 1
) (
   input  logic [CAW-1:0]   col_addr,
   input  logic [RUN_W-1:0] run_len,
   output logic [COLS-1:0]  col_en
);
   logic [SUMW-1:0] first_col;
   logic [SUMW-1:0] last_col;

   assign first_col = SUMW'(col_addr);
   assign last_col  = SUMW'(col_addr) + SUMW'(run_len);

   if (STYLE == 0) begin : g_cmp
      // one magnitude comparator pair per column
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam logic [SUMW-1:0] CIDX = SUMW'(c);
         assign col_en[c] = (CIDX >= first_col) && (CIDX <= last_col);
      end
   end else begin : g_mask
      // lower mask from start, upper mask from end+1, intersect
      localparam int unsigned MW = COLS + (1 << RUN_W) + 1;
      logic [MW-1:0] lo_mask;
      logic [MW-1:0] hi_mask;
      logic [SUMW:0] stop_col;
      assign stop_col = {1'b0, last_col} + 1'b1;
      assign lo_mask  = {MW{1'b1}} << first_col;
      assign hi_mask  = ~({MW{1'b1}} << stop_col);
      assign col_en   = lo_mask[COLS-1:0] & hi_mask[COLS-1:0];
   end
endmodule

// File: rtl/rscan_cell_grid.sv
module rscan_cell_grid #(
   parameter int unsigned ROWS = 8,
   parameter int unsigned COLS = 16,
   localparam int unsigned NCELL = ROWS * COLS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ROWS-1:0]  row_sel,
   input  logic [COLS-1:0]  col_en,
   input  logic             din,
   output logic [NCELL-1:0] cells,
   output logic [COLS-1:0]  rd_row
);
   logic [COLS-1:0] row_bits [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [COLS-1:0] cell_we;
      assign cell_we = col_en & {COLS{wr_en & row_sel[r]}};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row_bits[r] <= '0;
         end else begin
            for (int c = 0; c < COLS; c++) begin
               if (cell_we[c]) row_bits[r][c] <= din;
            end
         end
      end

      assign cells[r*COLS +: COLS] = row_bits[r];
   end

   always_comb begin
      rd_row = '0;
      for (int r = 0; r < ROWS; r++) begin
         rd_row = rd_row | (row_bits[r] & {COLS{row_sel[r]}});
      end
   end
endmodule

// File: rtl/rscan_misr.sv
module rscan_misr #(
   parameter int unsigned W    = 16,
   parameter logic [W-1:0] POLY = W'(16'h002D)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic [W-1:0] din,
   output logic [W-1:0] sig
);
   logic [W-1:0] sig_nxt;

   always_comb begin
      sig_nxt = {sig[W-2:0], 1'b0} ^ din;
      if (sig[W-1]) sig_nxt = sig_nxt ^ POLY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sig <= '0;
      else if (shift_en) sig <= sig_nxt;
   end
endmodule

// File: rtl/rscan_range_array.sv
module rscan_range_array #(
   parameter int unsigned ROWS      = 8,
   parameter int unsigned COLS      = 16,
   parameter int unsigned RUN_W     = 3,
   parameter int unsigned DEC_STYLE = 0,
   parameter logic [COLS-1:0] POLY  = COLS'(16'h002D),
   localparam int unsigned RAW   = $clog2(ROWS),
   localparam int unsigned CAW   = $clog2(COLS),
   localparam int unsigned NCELL = ROWS * COLS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             test_en,
   input  logic             wr_mode,
   input  logic [RAW-1:0]   row_addr,
   input  logic [CAW-1:0]   col_addr,
   input  logic [RUN_W-1:0] run_len,
   input  logic             scan_din,
   output logic [NCELL-1:0] cell_q,
   output logic [COLS-1:0]  signature
);
   import rscan_pkg::*;

   if (ROWS < 2)            begin : g_bad_rows  $error("ROWS must be at least 2");          end
   if (COLS < 2)            begin : g_bad_cols  $error("COLS must be at least 2");          end
   if (RUN_W < 1)           begin : g_bad_run   $error("RUN_W must be at least 1");         end
   if (RUN_W > CAW)         begin : g_long_run  $error("RUN_W must not exceed column bits"); end
   if (DEC_STYLE > 1)       begin : g_bad_style $error("DEC_STYLE must be 0 or 1");         end

   rscan_op_e       op;
   logic            do_write;
   logic            do_read;
   logic [ROWS-1:0] row_sel;
   logic [COLS-1:0] col_en;
   logic [COLS-1:0] rd_row;

   assign op       = rscan_decode_op(test_en, wr_mode);
   assign do_write = (op == OP_WRITE);
   assign do_read  = (op == OP_READ);

   rscan_row_dec #(.ROWS(ROWS)) u_row_dec (
      .row_addr (row_addr),
      .enable   (do_write | do_read),
      .row_sel  (row_sel)
   );

   rscan_col_range_dec #(.COLS(COLS), .RUN_W(RUN_W), .STYLE(DEC_STYLE)) u_col_dec (
      .col_addr (col_addr),
      .run_len  (run_len),
      .col_en   (col_en)
   );

   rscan_cell_grid #(.ROWS(ROWS), .COLS(COLS)) u_grid (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (do_write),
      .row_sel (row_sel),
      .col_en  (col_en),
      .din     (scan_din),
      .cells   (cell_q),
      .rd_row  (rd_row)
   );

   rscan_misr #(.W(COLS), .POLY(POLY)) u_misr (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (do_read),
      .din      (rd_row),
      .sig      (signature)
   );
endmodule

// File: rtl/rscan_range_array_chk.sv
module rscan_range_array_chk #(
   parameter int unsigned ROWS  = 8,
   parameter int unsigned COLS  = 16,
   parameter int unsigned RUN_W = 3,
   localparam int unsigned RAW   = $clog2(ROWS),
   localparam int unsigned CAW   = $clog2(COLS),
   localparam int unsigned NCELL = ROWS * COLS,
   localparam int unsigned IW    = $clog2(NCELL)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             test_en,
   input logic             wr_mode,
   input logic [RAW-1:0]   row_addr,
   input logic [CAW-1:0]   col_addr,
   input logic [RUN_W-1:0] run_len,
   input logic             scan_din,
   input logic [NCELL-1:0] cell_q,
   input logic [COLS-1:0]  signature
);
   logic             prev_wr;
   logic             prev_single;
   logic [IW-1:0]    prev_idx;
   logic             prev_din;
   logic [NCELL-1:0] prev_cells;
   logic [NCELL-1:0] prev_rowmask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_wr      <= 1'b0;
         prev_single  <= 1'b0;
         prev_idx     <= '0;
         prev_din     <= 1'b0;
         prev_cells   <= '0;
         prev_rowmask <= '0;
      end else begin
         prev_wr      <= test_en && wr_mode && (int'(row_addr) < ROWS) && (int'(col_addr) < COLS);
         prev_single  <= test_en && wr_mode && (run_len == '0);
         prev_idx     <= IW'(int'(row_addr) * COLS + int'(col_addr));
         prev_din     <= scan_din;
         prev_cells   <= cell_q;
         prev_rowmask <= {{(NCELL-COLS){1'b0}}, {COLS{1'b1}}} << (int'(row_addr) * COLS);
      end
   end

   // R3: the start cell of a run always takes the data bit
   a_r3_start_cell: assert property (@(posedge clk) disable iff (!rst_n)
      prev_wr |-> (cell_q[prev_idx] == prev_din));

   // R2: zero run length changes at most one cell
   a_r2_single_cell: assert property (@(posedge clk) disable iff (!rst_n)
      prev_single |-> ($countones(cell_q ^ prev_cells) <= 1));

   // R5: a write leaves every other row untouched
   a_r5_other_rows: assert property (@(posedge clk) disable iff (!rst_n)
      prev_wr |-> (((cell_q ^ prev_cells) & ~prev_rowmask) == '0));

   // R6: no write without test enable and write mode
   a_r6_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(test_en && wr_mode) |=> $stable(cell_q));

   // R9: signature holds outside reads
   a_r9_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(test_en && !wr_mode) |=> $stable(signature));
endmodule

bind rscan_range_array rscan_range_array_chk #(.ROWS(ROWS), .COLS(COLS), .RUN_W(RUN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .test_en   (test_en),
   .wr_mode   (wr_mode),
   .row_addr  (row_addr),
   .col_addr  (col_addr),
   .run_len   (run_len),
   .scan_din  (scan_din),
   .cell_q    (cell_q),
   .signature (signature)
);

// File: tb/rscan_range_array_tb.sv
`timescale 1ns/1ps
module rscan_range_array_tb;
   localparam int ROWS  = 8;
   localparam int COLS  = 16;
   localparam int RUN_W = 3;
   localparam int RAW   = $clog2(ROWS);
   localparam int CAW   = $clog2(COLS);
   localparam int NCELL = ROWS * COLS;
   localparam logic [COLS-1:0] POLY = 16'h002D;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             test_en = 1'b0;
   logic             wr_mode = 1'b0;
   logic [RAW-1:0]   row_addr = '0;
   logic [CAW-1:0]   col_addr = '0;
   logic [RUN_W-1:0] run_len = '0;
   logic             scan_din = 1'b0;
   logic [NCELL-1:0] cell_q;
   logic [COLS-1:0]  signature;

   always #5 clk = ~clk;

   rscan_range_array #(.ROWS(ROWS), .COLS(COLS), .RUN_W(RUN_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .test_en(test_en), .wr_mode(wr_mode),
      .row_addr(row_addr), .col_addr(col_addr), .run_len(run_len),
      .scan_din(scan_din), .cell_q(cell_q), .signature(signature)
   );

   typedef struct {
      logic [NCELL-1:0] cells;
      logic [COLS-1:0]  sig;
      string            tag;
   } exp_t;

   exp_t             sb_q[$];
   logic [NCELL-1:0] m_cells = '0;
   logic [COLS-1:0]  m_sig = '0;
   int               checks = 0;
   int               errors = 0;
   bit               done = 1'b0;
   bit               mon_on = 1'b0;

   // driver: apply one cycle of stimulus and push the expected result
   task automatic drive(input bit te, input bit wm, input int r, input int c,
                        input int n, input bit d, input string tag);
      exp_t e;
      logic [COLS-1:0] row;
      logic [COLS-1:0] nxt;
      @(negedge clk);
      test_en  = te;
      wr_mode  = wm;
      row_addr = RAW'(r);
      col_addr = CAW'(c);
      run_len  = RUN_W'(n);
      scan_din = d;
      if (te && wm) begin
         for (int k = 0; k < COLS; k++)
            if (k >= c && k <= c + n) m_cells[r*COLS + k] = d;
      end else if (te && !wm) begin
         row = m_cells[r*COLS +: COLS];
         nxt = {m_sig[COLS-2:0], 1'b0} ^ row;
         if (m_sig[COLS-1]) nxt = nxt ^ POLY;
         m_sig = nxt;
      end
      e.cells = m_cells;
      e.sig   = m_sig;
      e.tag   = tag;
      sb_q.push_back(e);
   endtask

   // monitor: compare after each rising edge, away from the edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (mon_on && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (cell_q !== e.cells || signature !== e.sig) begin
               errors++;
               $display("FAIL %s: cells=%h sig=%h expected cells=%h sig=%h",
                        e.tag, cell_q, signature, e.cells, e.sig);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (cell_q !== '0 || signature !== '0) begin
         errors++;
         $display("FAIL R1 reset: cells=%h sig=%h expected 0 and 0", cell_q, signature);
      end
      mon_on = 1'b1;

      drive(1, 1, 3, 2, 4, 1, "R4 example run row3 col2..6");
      drive(1, 1, 0, 5, 0, 1, "R2 single cell row0 col5");
      drive(1, 1, 3, 4, 1, 0, "R3 clear run row3 col4..5");
      drive(1, 1, 3, 0, 0, 1, "R7 row3 col0 only");
      drive(1, 1, 2, 14, 5, 1, "R5 clipped run row2 col14..15");
      drive(1, 1, 7, 13, 7, 1, "R5 clipped run last row");
      drive(0, 1, 1, 0, 7, 1, "R6 write ignored test_en low");
      drive(1, 0, 4, 0, 7, 1, "R8 read row4 and R6 no write");
      drive(1, 0, 3, 0, 0, 0, "R8 read row3");
      drive(1, 0, 2, 0, 0, 0, "R8 read row2");
      drive(0, 0, 0, 0, 0, 0, "R9 idle hold");
      drive(1, 1, 5, 15, 0, 1, "R2 single cell last column");
      drive(1, 1, 5, 8, 7, 1, "R3 full length run");
      drive(1, 1, 5, 10, 2, 0, "R7 inner clear keeps neighbours");
      drive(1, 0, 5, 0, 0, 0, "R8 read row5");
      drive(1, 0, 7, 0, 0, 0, "R8 read row7");

      for (int i = 0; i < 300; i++) begin
         int unsigned v;
         v = $urandom;
         drive(v[0] | v[1], v[2], int'(v[5:3]), int'(v[9:6]), int'(v[12:10]),
               v[13], "R3 R8 mixed random");
      end
      drive(0, 0, 0, 0, 0, 0, "R9 final idle");

      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule